// File: doc/BRIEF.md
# Register File with Constant Location

This block is a small synchronous register file for an 8-bit datapath. It has one write port, made of a strobe, a 2-bit location select and a data word. It also has one read port, made of a 2-bit location select and a data word that is produced combinationally. Locations 0, 1 and 2 are ordinary storage. Location 3 holds nothing. Reading it returns a small constant (zero, minus one or plus one), and the value of the write-side location select chooses which constant, not anything stored.

Write enables come from an enabled 2-to-4 decoder. The read path has two selection stages. The first turns the write select into the constant word. The second is a 4:1 multiplexer on the read select that chooses among the three registers and that constant. The read port shows a write only after the clock edge that performs it; a write in the same cycle is not forwarded to the read port. Both ports are plain register-file pins with no valid/ready pairing. A write completes in one cycle and a read is combinational, so neither port can apply back-pressure.

Top module: `cgreg_file`

## Requirements
- R1: A synchronous active-high reset clears locations 0, 1 and 2 to 8'h00 on the rising clock edge.
- R2: With `st_strobe` high and `st_sel` equal to 0, 1 or 2, the selected location loads `st_value` on the rising edge.
- R3: With `st_strobe` low, no location changes at a clock edge.
- R4: A write with `st_sel` equal to 3 changes no location.
- R5: Reading location 3 returns 8'h00 when `st_sel` is 0, 8'hFF when it is 1, 8'h01 when it is 2, and 8'h00 when it is 3. The strobe has no effect on this value.
- R6: The read is combinational. During the cycle of a write, `ld_value` still shows the old content of the target location, and it shows the new content after the edge.
- R7: A write to one location leaves the other two locations unchanged.
- R8: Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_strobe | input | 1 | Write strobe |
| st_sel | input | 2 | Write location; also picks the constant seen at location 3 |
| st_value | input | 8 | Write data |
| ld_sel | input | 2 | Read location |
| ld_value | output | 8 | Read data, combinational |

## Verification
The bench reads location 3 under all four write selects, with the strobe both high and low. A design that decodes the constant from the read select, or that forgets the select-3 case, returns the wrong word there. It also reads the target of a write in the same cycle as the write. A design with a bypass path shows the new data one cycle early. Writes to location 3 are followed by reads of every location, which exposes a decoder that aliases select 3 onto a real register. A reset issued together with a write shows whether the reset really wins.

// File: rtl/cgreg_pkg.sv
package cgreg_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_SEL_W  = 2;

  typedef enum logic [1:0] {
    K_ZERO  = 2'd0,
    K_MINUS = 2'd1,
    K_PLUS  = 2'd2,
    K_SPARE = 2'd3
  } kconst_e;
endpackage

// File: rtl/cgreg_wdec.sv
module cgreg_wdec #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned NOUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NOUT-1:0]  hot
);
  for (genvar i = 0; i < NOUT; i++) begin : g_line
    assign hot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/cgreg_kgen.sv
module cgreg_kgen
  import cgreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [1:0]        code,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    unique case (kconst_e'(code))
      K_MINUS: word = '1;
      K_PLUS:  word = DATA_W'(1);
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/cgreg_rmux.sv
module cgreg_rmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NIN   = 1 << SEL_W
) (
  input  logic [NIN-1:0][DATA_W-1:0] src,
  input  logic [SEL_W-1:0]           sel,
  output logic [DATA_W-1:0]          out
);
  always_comb out = src[sel];
endmodule

// File: rtl/cgreg_file.sv
module cgreg_file
  import cgreg_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SEL_W  = DEF_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_strobe,
  input  logic [SEL_W-1:0]  st_sel,
  input  logic [DATA_W-1:0] st_value,
  input  logic [SEL_W-1:0]  ld_sel,
  output logic [DATA_W-1:0] ld_value
);
  localparam int unsigned NLOC = 1 << SEL_W;
  localparam int unsigned NGP  = NLOC - 1;

  logic [NLOC-1:0]             dec_en;
  logic [NGP-1:0][DATA_W-1:0]  store_q;
  logic [DATA_W-1:0]           kword;
  logic [NLOC-1:0][DATA_W-1:0] rsrc;

  cgreg_wdec #(.SEL_W(SEL_W)) u_wdec (
    .en  (st_strobe),
    .sel (st_sel),
    .hot (dec_en)
  );

  for (genvar i = 0; i < NGP; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            store_q[i] <= '0;
      else if (dec_en[i]) store_q[i] <= st_value;
    end
    assign rsrc[i] = store_q[i];
  end

  cgreg_kgen #(.DATA_W(DATA_W)) u_kgen (
    .code (st_sel[1:0]),
    .word (kword)
  );
  assign rsrc[NLOC-1] = kword;

  cgreg_rmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rmux (
    .src (rsrc),
    .sel (ld_sel),
    .out (ld_value)
  );
endmodule

// File: rtl/cgreg_file_chk.sv
module cgreg_file_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NLOC  = 1 << SEL_W,
  localparam int unsigned NGP   = NLOC - 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       st_strobe,
  input logic [SEL_W-1:0]           st_sel,
  input logic [DATA_W-1:0]          st_value,
  input logic [SEL_W-1:0]           ld_sel,
  input logic [DATA_W-1:0]          ld_value,
  input logic [NLOC-1:0]            dec_en,
  input logic [NGP-1:0][DATA_W-1:0] store_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store_q == '0));

  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    (st_strobe && (st_sel != SEL_W'(NLOC-1))) |=> (store_q[$past(st_sel)] == $past(st_value)));

  p_dec_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_en));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !st_strobe |=> $stable(store_q));

  p_top_readonly_r4: assert property (@(posedge clk) disable iff (rst)
    (st_strobe && (st_sel == SEL_W'(NLOC-1))) |=> $stable(store_q));

  p_const_minus_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_sel == SEL_W'(NLOC-1) && st_sel == SEL_W'(1)) |-> (ld_value == '1));

  p_const_plus_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_sel == SEL_W'(NLOC-1) && st_sel == SEL_W'(2)) |-> (ld_value == DATA_W'(1)));
endmodule

bind cgreg_file cgreg_file_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st_strobe (st_strobe),
  .st_sel    (st_sel),
  .st_value  (st_value),
  .ld_sel    (ld_sel),
  .ld_value  (ld_value),
  .dec_en    (dec_en),
  .store_q   (store_q)
);

// File: tb/tb_cgreg_file.sv
`timescale 1ns/1ps
module tb_cgreg_file;
  logic       clk = 1'b0;
  logic       rst;
  logic       st_strobe;
  logic [1:0] st_sel;
  logic [7:0] st_value;
  logic [1:0] ld_sel;
  logic [7:0] ld_value;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [3];

  always #5 clk = ~clk;

  cgreg_file dut (
    .clk(clk), .rst(rst), .st_strobe(st_strobe), .st_sel(st_sel),
    .st_value(st_value), .ld_sel(ld_sel), .ld_value(ld_value)
  );

  function automatic logic [7:0] kval(input logic [1:0] s);
    case (s)
      2'd1:    return 8'hFF;
      2'd2:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expect_rd(input logic [1:0] r, input logic [1:0] s);
    return (r == 2'd3) ? kval(s) : mdl[r];
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // drive at negedge, check combinational read, then apply the edge to the model
  task automatic cyc(input logic r, input logic w, input logic [1:0] ws,
                     input logic [7:0] wv, input logic [1:0] rs, input string tag);
    @(negedge clk);
    rst = r; st_strobe = w; st_sel = ws; st_value = wv; ld_sel = rs;
    #1;
    chk(tag, ld_value, expect_rd(rs, ws));
    @(posedge clk);
    if (r) for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
    else if (w && ws != 2'd3) mdl[ws] = wv;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00, 2'(i), tag);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 3; i++) mdl[i] = 8'hxx;
    rst = 1'b1; st_strobe = 1'b0; st_sel = 2'd0; st_value = 8'h00; ld_sel = 2'd3;
    @(posedge clk);
    for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
    // R1: reset contents
    read_all("R1 reset value");
    // R2 / R7: fill each location with distinct data
    cyc(1'b0, 1'b1, 2'd0, 8'hA5, 2'd1, "R2 write r0");
    cyc(1'b0, 1'b1, 2'd1, 8'h3C, 2'd0, "R2 readback r0");
    cyc(1'b0, 1'b1, 2'd2, 8'h77, 2'd1, "R7 r1 after write");
    read_all("R7 independent locations");
    // R6: same-cycle read shows old value
    cyc(1'b0, 1'b1, 2'd1, 8'hC3, 2'd1, "R6 no bypass");
    cyc(1'b0, 1'b0, 2'd0, 8'h00, 2'd1, "R6 visible after edge");
    // R4: writes at the top location change nothing
    cyc(1'b0, 1'b1, 2'd3, 8'hEE, 2'd3, "R4 write top");
    cyc(1'b0, 1'b1, 2'd3, 8'h11, 2'd0, "R4 write top");
    read_all("R4 no register changed");
    // R3: idle strobe with data wiggling
    cyc(1'b0, 1'b0, 2'd2, 8'h99, 2'd2, "R3 idle");
    read_all("R3 hold");
    // R5: every constant code, strobe low and high (top-location write)
    for (int s = 0; s < 4; s++) cyc(1'b0, 1'b0, 2'(s), 8'h5A, 2'd3, "R5 constant");
    cyc(1'b0, 1'b1, 2'd3, 8'h5A, 2'd3, "R5 constant sel3 strobe");
    cyc(1'b0, 1'b1, 2'd1, 8'h42, 2'd3, "R5 constant sel1 strobe");
    // R8: reset wins over write
    cyc(1'b1, 1'b1, 2'd0, 8'hFE, 2'd0, "R8 reset with write");
    read_all("R8 reset priority");
    // random traffic
    for (int n = 0; n < 600; n++) begin
      cyc(($urandom % 40) == 0, $urandom % 2 == 0, 2'($urandom), 8'($urandom),
          2'($urandom), "R2 R5 random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule